// File: doc/BRIEF.md
# Eight-bit Event Timer with Selectable Prescaler

This block is an 8-bit up-counter that software controls through a small register bus. Each count step comes from one of two sources. The first is an internal cycle tick that fires once every four system clocks. The second is an external clock pin, which is synchronised into the system clock domain and counted on the edge that software picks. A power-of-two prescaler can be placed in the count path, or bypassed so that every source event advances the counter.

When the counter wraps from its top value to zero, a sticky overflow flag is set. The interrupt output is high while both that flag and its enable bit are set. No part of the block carries streaming data, so every pin is a plain level or pulse. A bus access completes in one cycle and has no back-pressure. Register reads are combinational. A write takes effect at the clock edge where `bus_en_i` and `bus_wr_i` are both high.

Top module: `tick_timer8`

## Requirements
- R1: After reset the control register (address 1) reads 0xFF, the count (address 0) reads 0x00, the status register (address 2) reads 0x00 and `irq_o` is low.
- R2: With control bit 5 at 0 the source is the internal tick, which fires once every four system clocks. With the prescaler bypassed, the count rises by exactly k in any 4·k consecutive clocks.
- R3: With control bit 5 at 1 the source is `ext_clk_i`, passed through a two-flop synchroniser. Control bit 4 at 0 counts low-to-high transitions of the pin; at 1 it counts high-to-low transitions.
- R4: With control bit 3 at 1 the prescaler is bypassed and every source event adds one to the count.
- R5: With control bit 3 at 0 the count advances once per 2^(rate+1) source events. The rate sits in control bits 2:0, so 000 gives 1:2 and 111 gives 1:256.
- R6: A write to address 0 loads the count with the written byte and clears the prescaler. If an increment falls in the same cycle, the write wins.
- R7: An increment from 0xFF leaves the count at 0x00 and sets the overflow flag, which is status bit 0.
- R8: `irq_o` is high exactly when the overflow flag and the interrupt enable (status bit 1) are both set.
- R9: The overflow flag stays set across reads. Only a write to address 2 with bit 0 at 0 clears it, and a wrap in the same cycle keeps it set.
- R10: Control bits 7 and 6 are stored and read back, and they have no effect on counting.
- R11: Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External count pin, asynchronous to `clk` |
| bus_en_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | High for a write, low for a read |
| bus_addr_i | input | 2 | Register address: 0 count, 1 control, 2 status |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit count, an 8-bit prescaler, a divide-by-four internal tick and two synchroniser stages. These values bring the 1:256 ratio within reach in a few hundred pin pulses. Wrap-around is reached from a preload of 0xFE or 0xF0. The internal tick can be checked exactly because any run of 4·k clocks holds k ticks, whatever the phase of the divider. Pin pulses last three clocks high and three low, which is long enough for the synchroniser. Each run ends with one extra rising edge, so a rising-edge setup and a falling-edge setup must give different counts.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int BUS_W = 8;

  typedef struct packed {
    logic       pull_off;   // stored only
    logic       pin_rise;   // stored only
    logic       src_pin;    // 1: external pin, 0: internal tick
    logic       fall_edge;  // 1: high-to-low, 0: low-to-high
    logic       bypass;     // 1: prescaler out of path
    logic [2:0] rate;       // ratio 2^(rate+1)
  } tmr_ctrl_t;

  localparam logic [1:0] A_COUNT  = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_STATUS = 2'd2;
  localparam logic [BUS_W-1:0] CTRL_RST = 8'hFF;
endpackage

// File: rtl/timer_pin_edge.sv
module timer_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl    = sync_q[STAGES-1];
  assign edge_o = fall_sel_i ? (prev_q & ~lvl) : (~prev_q & lvl);
endmodule

// File: rtl/timer_cycle_tick.sv
module timer_cycle_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int PRE_W = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              ev_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              out_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (ev_i)  cnt_q <= cnt_q + 1'b1;
  end

  // low (rate+1) bits set
  assign mask  = ~({PRE_W{1'b1}} << ({1'b0, rate_i} + 1'b1));
  assign out_o = ev_i && ((cnt_q & mask) == mask);
endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import timer_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int CYC_DIV     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk_i,
  input  logic             bus_en_i,
  input  logic             bus_wr_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [BUS_W-1:0] bus_wdata_i,
  output logic [BUS_W-1:0] bus_rdata_o,
  output logic             irq_o
);
  localparam logic [BUS_W-1:0] TOP = {BUS_W{1'b1}};

  tmr_ctrl_t        ctrl_q;
  logic [BUS_W-1:0] count_q;
  logic             flag_q, en_q;
  logic             pin_ev, cyc_ev, src_ev, pre_ev, inc_pulse;
  logic             wr_cnt, wr_ctrl, wr_stat, wrap;

  assign wr_cnt  = bus_en_i && bus_wr_i && (bus_addr_i == A_COUNT);
  assign wr_ctrl = bus_en_i && bus_wr_i && (bus_addr_i == A_CTRL);
  assign wr_stat = bus_en_i && bus_wr_i && (bus_addr_i == A_STATUS);

  timer_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_clk_i),
    .fall_sel_i(ctrl_q.fall_edge), .edge_o(pin_ev)
  );

  timer_cycle_tick #(.DIV(CYC_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(cyc_ev)
  );

  assign src_ev = ctrl_q.src_pin ? pin_ev : cyc_ev;

  timer_prescaler #(.PRE_W(PRE_W), .RATE_W(3)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr_i(wr_cnt), .ev_i(src_ev),
    .rate_i(ctrl_q.rate), .out_o(pre_ev)
  );

  assign inc_pulse = ctrl_q.bypass ? src_ev : pre_ev;
  assign wrap      = inc_pulse && !wr_cnt && (count_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ctrl_q  <= tmr_ctrl_t'(CTRL_RST);
      flag_q  <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      if (wr_cnt)         count_q <= bus_wdata_i;
      else if (inc_pulse) count_q <= count_q + 1'b1;
      if (wr_ctrl) ctrl_q <= tmr_ctrl_t'(bus_wdata_i);
      if (wr_stat) en_q <= bus_wdata_i[1];
      if (wrap)         flag_q <= 1'b1;
      else if (wr_stat) flag_q <= bus_wdata_i[0];
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      A_COUNT:  bus_rdata_o = count_q;
      A_CTRL:   bus_rdata_o = ctrl_q;
      A_STATUS: bus_rdata_o = {{(BUS_W-2){1'b0}}, en_q, flag_q};
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q & en_q;
endmodule

// File: rtl/tick_timer8_chk.sv
module tick_timer8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en_i,
  input logic       bus_wr_i,
  input logic [1:0] bus_addr_i,
  input logic [7:0] bus_wdata_i,
  input logic [7:0] count_q,
  input logic       inc_pulse,
  input logic       flag_q,
  input logic       en_q,
  input logic       irq_o
);
  logic cnt_w, stat_w;
  assign cnt_w  = bus_en_i && bus_wr_i && (bus_addr_i == 2'd0);
  assign stat_w = bus_en_i && bus_wr_i && (bus_addr_i == 2'd2);

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_pulse && !cnt_w) |=> (count_q == $past(count_q) + 8'd1)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_pulse && !cnt_w) |=> $stable(count_q)); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_w |=> (count_q == $past(bus_wdata_i))); // R6
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_pulse && !cnt_w && count_q == 8'hFF) |=> (flag_q && count_q == 8'h00)); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q && flag_q)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !stat_w) |=> flag_q); // R9
endmodule

bind tick_timer8 tick_timer8_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en_i(bus_en_i), .bus_wr_i(bus_wr_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .count_q(count_q),
  .inc_pulse(inc_pulse), .flag_q(flag_q), .en_q(en_q), .irq_o(irq_o)
);

// File: tb/sim_tick_timer8.sv
module sim_tick_timer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       bus_en_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       irq_o;
  int checks = 0;
  int errors = 0;
  logic [7:0] rd;

  always #5 clk = ~clk;

  tick_timer8 u0 (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i), .bus_en_i(bus_en_i),
    .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  // {ctrl, preload, full pulses, expected count}
  localparam logic [39:0] VEC [7] = '{
    {8'h28, 8'd10,  16'd5,  8'd16},  // R3 R4 rising
    {8'h38, 8'd10,  16'd5,  8'd15},  // R3 falling
    {8'hE8, 8'd0,   16'd3,  8'd4},   // R10 stored bits set
    {8'h20, 8'd0,   16'd6,  8'd3},   // R5 1:2
    {8'h22, 8'd0,   16'd16, 8'd2},   // R5 1:8
    {8'h31, 8'd0,   16'd9,  8'd2},   // R5 1:4 falling
    {8'h28, 8'hF0,  16'd20, 8'h05}   // R7 wrap
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_en_i = 1'b1; bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk);
    @(negedge clk);
    bus_en_i = 1'b0; bus_wr_i = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr_i = a;
    #1 d = bus_rdata_o;
  endtask

  task automatic pulse();
    @(negedge clk) ext_clk_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) ext_clk_i = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    rdreg(2'd1, rd); check("R1 ctrl", rd, 8'hFF);
    rdreg(2'd0, rd); check("R1 count", rd, 8'h00);
    rdreg(2'd2, rd); check("R1 status", rd, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);

    foreach (VEC[i]) begin
      wr(2'd1, VEC[i][39:32]);
      wr(2'd2, 8'h00);
      wr(2'd0, VEC[i][31:24]);
      for (int p = 0; p < int'(VEC[i][23:8]); p++) pulse();
      @(negedge clk) ext_clk_i = 1'b1;
      repeat (6) @(posedge clk);
      rdreg(2'd0, rd); check($sformatf("R3/R4/R5 vec %0d", i), rd, VEC[i][7:0]);
      rdreg(2'd1, rd); check("R10 readback", rd, VEC[i][39:32]);
      @(negedge clk) ext_clk_i = 1'b0;
      repeat (6) @(posedge clk);
    end

    // R2 internal tick, bypass and 1:2
    wr(2'd1, 8'h08); wr(2'd0, 8'h00);
    repeat (40) @(posedge clk);
    rdreg(2'd0, rd); check("R2 internal bypass", rd, 8'd10);
    wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    repeat (40) @(posedge clk);
    rdreg(2'd0, rd); check("R2 R5 internal 1:2", rd, 8'd5);

    // R6 count write clears prescaler
    wr(2'd1, 8'h20); wr(2'd0, 8'h00);
    pulse();
    wr(2'd0, 8'h05);
    pulse(); repeat (3) @(posedge clk);
    rdreg(2'd0, rd); check("R6 prescaler cleared", rd, 8'h05);
    pulse(); repeat (3) @(posedge clk);
    rdreg(2'd0, rd); check("R6 after second event", rd, 8'h06);

    // R5 1:256
    wr(2'd1, 8'h27); wr(2'd0, 8'h00);
    for (int p = 0; p < 255; p++) pulse();
    repeat (3) @(posedge clk);
    rdreg(2'd0, rd); check("R5 1:256 before", rd, 8'h00);
    pulse(); repeat (3) @(posedge clk);
    rdreg(2'd0, rd); check("R5 1:256 step", rd, 8'h01);

    // R7 R8 R9 overflow and interrupt
    wr(2'd1, 8'h28); wr(2'd2, 8'h00); wr(2'd0, 8'hFE);
    pulse(); pulse(); repeat (3) @(posedge clk);
    rdreg(2'd0, rd); check("R7 wrap count", rd, 8'h00);
    rdreg(2'd2, rd); check("R7 flag set", rd, 8'h01);
    check("R8 irq masked", {7'd0, irq_o}, 8'h00);
    rdreg(2'd2, rd); check("R9 flag kept after read", rd, 8'h01);
    wr(2'd2, 8'h03);
    check("R8 irq enabled", {7'd0, irq_o}, 8'h01);
    wr(2'd2, 8'h02);
    rdreg(2'd2, rd); check("R9 flag cleared", rd, 8'h02);
    check("R8 irq after clear", {7'd0, irq_o}, 8'h00);
    rdreg(2'd3, rd); check("R11 unused address", rd, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule